// File: doc/BRIEF.md
# Prioritised Interrupt Controller

The block collects 32 external interrupt lines and keeps two bits of state per line: whether the line is enabled and whether it is pending. Software changes the state through write-one registers. One address sets bits and a second address clears them, so a line can be changed without a read-modify-write. A rising level on an input marks that line pending. A 2-bit priority per line is stored in four-lines-per-word registers.

From this state a combinational tree works out the best request every cycle. It picks the pending, enabled line with the numerically lowest priority value, and a lower line number wins a tie. It reports that line as an exception number, which is the line number plus 16. A single-level acknowledge handshake takes the reported request: it clears its pending bit and holds its number as active until end-of-interrupt.

Top module: `prio_intc`

## Requirements
- R1: A write to 0x100 sets the enable bit of every line whose data bit is 1 and leaves lines written with 0 unchanged. A read of 0x100 returns the enable vector, with line n at bit n.
- R2: A write to 0x180 clears the enable bit of every line whose data bit is 1. A read of 0x180 also returns the enable vector.
- R3: Writes to 0x200 and 0x280 set and clear pending bits with the same write-one rule. Reads of either address return the pending vector.
- R4: A 0-to-1 change on irq_i[n], seen between two consecutive clock edges, sets pending bit n. An input held high does not set the bit again after it has been cleared.
- R5: The priority word at 0x400+4k holds line 4k+j in bits 8j+7:8j+6, for j from 0 to 3. Value 0 is the most urgent. All other bits of these words read as 0, and writes to them are ignored.
- R6: pend_num_o equals n+16 for the best pending, enabled line n. It equals 0, with pend_any_o low, when no line is both pending and enabled.
- R7: Among pending, enabled lines of equal priority, the lowest line number is reported.
- R8: ack_i, while pend_any_o is high and active_vld_o is low, clears the pending bit of the reported line. It also loads active_num_o with the reported number and raises active_vld_o. eoi_i drops active_vld_o and returns active_num_o to 0. ack_i while a request is active is ignored.
- R9: When a set from an input edge and a clear of the same pending bit, from a clear-pending write or an acknowledge, occur in the same cycle, the bit ends up clear.
- R10: After reset all enable, pending and priority state is 0 and no request is reported. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Byte address of register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_i | input | 32 | Interrupt request lines |
| ack_i | input | 1 | Acknowledge of the reported request |
| eoi_i | input | 1 | End of the active interrupt |
| pend_num_o | output | 6 | Best pending exception number, 0 if none |
| pend_any_o | output | 1 | Some enabled line is pending |
| active_num_o | output | 6 | Exception number being serviced |
| active_vld_o | output | 1 | An interrupt is active |

## Verification
Every state change takes one clock edge. A write, an input edge, an acknowledge or an end-of-interrupt presented before edge k appears in the register reads and in pend_num_o, pend_any_o, active_num_o and active_vld_o straight after edge k. The results are combinational from state, so no further delay is added. The bench therefore drives each stimulus on a falling edge and removes it on the next falling edge. It compares reads and outputs at that second falling edge, half a cycle clear of any capturing edge. The resolver is checked against an arithmetic model over single-line sweeps and pseudo-random enable, pending and priority sets.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int NUM_OFS = 16;
  localparam int PRIO_W = 2;

  localparam logic [ADDR_W-1:0] A_SET_EN   = 12'h100;
  localparam logic [ADDR_W-1:0] A_CLR_EN   = 12'h180;
  localparam logic [ADDR_W-1:0] A_SET_PEND = 12'h200;
  localparam logic [ADDR_W-1:0] A_CLR_PEND = 12'h280;
  localparam logic [ADDR_W-1:0] A_PRIO     = 12'h400;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_LINES = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  input  logic [N_LINES-1:0]        irq_i,
  input  logic [N_LINES-1:0]        hw_clr_i,
  output logic [N_LINES-1:0]        en_o,
  output logic [N_LINES-1:0]        pend_o,
  output logic [N_LINES*PRIO_W-1:0] prio_o
);
  localparam int N_WORDS = N_LINES / 4;

  logic [N_LINES-1:0] irq_q, rise, wmask;
  logic [N_LINES-1:0] en_set, en_clr, pd_set, pd_clr;
  logic [PRIO_W-1:0]  prio_q [N_LINES];

  assign wmask  = wdata_i[N_LINES-1:0];
  assign rise   = irq_i & ~irq_q;
  assign en_set = (we_i && addr_i == A_SET_EN) ? wmask : '0;
  assign en_clr = (we_i && addr_i == A_CLR_EN) ? wmask : '0;
  assign pd_set = rise | ((we_i && addr_i == A_SET_PEND) ? wmask : '0);
  assign pd_clr = hw_clr_i | ((we_i && addr_i == A_CLR_PEND) ? wmask : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      en_o   <= '0;
      pend_o <= '0;
    end else begin
      irq_q  <= irq_i;
      en_o   <= (en_o | en_set) & ~en_clr;
      pend_o <= (pend_o | pd_set) & ~pd_clr;  // clear wins
    end
  end

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] WADDR = A_PRIO + ADDR_W'(4 * w);
    for (genvar j = 0; j < 4; j++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prio_q[4*w+j] <= '0;
        else if (we_i && addr_i == WADDR) prio_q[4*w+j] <= wdata_i[8*j+7 -: PRIO_W];
      end
      assign prio_o[(4*w+j)*PRIO_W +: PRIO_W] = prio_q[4*w+j];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_SET_EN || addr_i == A_CLR_EN) rdata_o = DATA_W'(en_o);
    else if (addr_i == A_SET_PEND || addr_i == A_CLR_PEND) rdata_o = DATA_W'(pend_o);
    else begin
      for (int w = 0; w < N_WORDS; w++) begin
        if (addr_i == A_PRIO + ADDR_W'(4 * w)) begin
          for (int j = 0; j < 4; j++) rdata_o[8*j+7 -: PRIO_W] = prio_q[4*w+j];
        end
      end
    end
  end

  AST_SET_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SET_EN) |=> ((en_o & $past(wmask)) == $past(wmask)))  // R1
    else $error("set-enable");
  AST_CLR_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CLR_PEND) |=> ((pend_o & $past(wmask)) == '0))  // R9
    else $error("clear-pending");
  AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0 && pd_clr == '0) |=> ((pend_o & $past(rise)) == $past(rise)))  // R4
    else $error("edge set");
endmodule

// File: rtl/intc_resolver.sv
module intc_resolver
  import intc_pkg::*;
#(
  parameter int N_LINES = 32,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0]        req_i,
  input  logic [N_LINES*PRIO_W-1:0] prio_i,
  output logic                      vld_o,
  output logic [IDX_W-1:0]          idx_o
);
  typedef struct packed {
    logic              vld;
    logic [PRIO_W-1:0] prio;
    logic [IDX_W-1:0]  idx;
  } node_t;

  // heap layout: node i has children 2i+1 (lower lines) and 2i+2
  node_t node [2*N_LINES-1];

  for (genvar n = 0; n < N_LINES; n++) begin : g_leaf
    assign node[N_LINES-1+n] = '{vld: req_i[n], prio: prio_i[n*PRIO_W +: PRIO_W],
                                 idx: IDX_W'(n)};
  end

  for (genvar i = 0; i < N_LINES-1; i++) begin : g_node
    node_t lo, hi;
    assign lo = node[2*i+1];
    assign hi = node[2*i+2];
    // right side only wins on a strictly better priority: ties go to lower line
    assign node[i] = (hi.vld && (!lo.vld || hi.prio < lo.prio)) ? hi : lo;
  end

  assign vld_o = node[0].vld;
  assign idx_o = node[0].vld ? node[0].idx : '0;

  AST_WIN_REQ: assert final (!vld_o || req_i[idx_o])  // R6
    else $error("winner not requesting");
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int N_LINES = 32,
  localparam int IDX_W  = $clog2(N_LINES),
  localparam int NUM_W  = $clog2(N_LINES + NUM_OFS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               ack_i,
  input  logic               eoi_i,
  output logic [NUM_W-1:0]   pend_num_o,
  output logic               pend_any_o,
  output logic [NUM_W-1:0]   active_num_o,
  output logic               active_vld_o
);
  logic [N_LINES-1:0]        en, pend, hw_clr;
  logic [N_LINES*PRIO_W-1:0] prio;
  logic                      win_vld, ack_take;
  logic [IDX_W-1:0]          win_idx;

  intc_regs #(.N_LINES(N_LINES)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_i,
    .hw_clr_i(hw_clr), .en_o(en), .pend_o(pend), .prio_o(prio)
  );

  intc_resolver #(.N_LINES(N_LINES)) u_res (
    .req_i(en & pend), .prio_i(prio), .vld_o(win_vld), .idx_o(win_idx)
  );

  assign pend_any_o = win_vld;
  assign pend_num_o = win_vld ? NUM_W'(win_idx) + NUM_W'(NUM_OFS) : '0;
  assign ack_take   = ack_i && win_vld && !active_vld_o;
  assign hw_clr     = ack_take ? (N_LINES'(1) << win_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_vld_o <= 1'b0;
      active_num_o <= '0;
    end else if (ack_take) begin
      active_vld_o <= 1'b1;
      active_num_o <= pend_num_o;
    end else if (eoi_i) begin
      active_vld_o <= 1'b0;
      active_num_o <= '0;
    end
  end

  AST_NUM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_any_o |-> (pend_num_o >= NUM_W'(NUM_OFS)))  // R6
    else $error("number range");
  AST_ANY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_any_o == ((en & pend) != '0))  // R6
    else $error("pending flag");
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_take |=> !pend[$past(win_idx)])  // R8
    else $error("ack clear");
  AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_vld_o && !eoi_i) |=> (active_vld_o && $stable(active_num_o)))  // R8
    else $error("active hold");
endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  localparam time CLK_P = 4ns;
  localparam int  N = 32;

  logic        clk = 0, rst_ni = 0, we = 0, ack = 0, eoi = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, irq = '0;
  logic [5:0]  pend_num, active_num;
  logic        pend_any, active_vld;

  int checks = 0, errors = 0;
  logic [31:0] m_en, m_pend, seed;
  logic [1:0]  m_prio [N];

  always #(CLK_P/2) clk = ~clk;

  prio_intc u_prio_intc (
    .clk_i(clk), .rst_ni, .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_i(irq), .ack_i(ack), .eoi_i(eoi), .pend_num_o(pend_num), .pend_any_o(pend_any),
    .active_num_o(active_num), .active_vld_o(active_vld)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [31:0] nxt(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  function automatic logic [5:0] exp_num();
    int best = -1;
    for (int n = 0; n < N; n++)
      if (m_en[n] && m_pend[n] && (best < 0 || m_prio[n] < m_prio[best])) best = n;
    return best < 0 ? 6'd0 : 6'(best + 16);
  endfunction

  task automatic load_model();
    wr(12'h180, '1); wr(12'h100, m_en);
    wr(12'h280, '1); wr(12'h200, m_pend);
    for (int w = 0; w < 8; w++)
      wr(12'h400 + 12'(4*w), {m_prio[4*w+3], 6'h3f, m_prio[4*w+2], 6'h3f,
                              m_prio[4*w+1], 6'h3f, m_prio[4*w], 6'h3f});
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R10 reset state and unmapped reads
    chk("R10 pend_any", 32'(pend_any), 0);
    chk("R10 pend_num", 32'(pend_num), 0);
    chk("R10 active", 32'(active_vld), 0);
    foreach (m_prio[i]) m_prio[i] = 0;
    for (int w = 0; w < 8; w++) begin rd(12'h400 + 12'(4*w), d); chk("R10 prio", d, 0); end
    rd(12'h100, d); chk("R10 enable", d, 0);
    rd(12'h200, d); chk("R10 pending", d, 0);
    wr(12'h300, '1); rd(12'h300, d); chk("R10 unmapped", d, 0);
    rd(12'h104, d); chk("R10 unmapped", d, 0);

    // R1 / R2 enable set and clear
    wr(12'h100, 32'hA5A5_0F0F); wr(12'h100, 32'h0000_0000);
    rd(12'h100, d); chk("R1 set-enable", d, 32'hA5A5_0F0F);
    wr(12'h100, 32'h0000_0030);
    rd(12'h180, d); chk("R1 set-enable or", d, 32'hA5A5_0F3F);
    wr(12'h180, 32'h8001_0101);
    rd(12'h180, d); chk("R2 clear-enable", d, 32'h25A4_0E3E);
    rd(12'h100, d); chk("R2 readback", d, 32'h25A4_0E3E);
    wr(12'h180, '1);

    // R3 pending set and clear
    wr(12'h200, 32'h1234_5678); wr(12'h200, 0);
    rd(12'h280, d); chk("R3 set-pending", d, 32'h1234_5678);
    wr(12'h280, 32'h0230_0070);
    rd(12'h200, d); chk("R3 clear-pending", d, 32'h1004_5608);
    chk("R6 disabled lines", 32'(pend_any), 0);
    wr(12'h280, '1);

    // R5 priority packing, sweep of all words
    for (int w = 0; w < 8; w++) begin
      wr(12'h400 + 12'(4*w), '1); rd(12'h400 + 12'(4*w), d);
      chk("R5 prio mask", d, 32'hC0C0_C0C0);
      wr(12'h400 + 12'(4*w), 32'h3F7F_BFFF ^ 32'(w)); rd(12'h400 + 12'(4*w), d);
      chk("R5 prio fields", d, 32'h0040_80C0);
    end

    // R6 single-line sweep at every priority
    foreach (m_prio[i]) m_prio[i] = 0;
    for (int n = 0; n < N; n++) begin
      m_en = 32'(1) << n; m_pend = 32'hFFFF_FFFF; m_prio[n] = 2'(n);
      load_model();
      chk("R6 single line", 32'(pend_num), 32'(n + 16));
      chk("R6 any flag", 32'(pend_any), 1);
      m_prio[n] = 0;
    end

    // R6 / R7 pseudo-random sets, includes empty and all-equal cases
    seed = 32'h1ACE_B00C;
    for (int t = 0; t < 60; t++) begin
      seed = nxt(seed); m_en = seed;
      seed = nxt(seed); m_pend = seed;
      seed = nxt(seed); m_pend &= seed;
      if (t == 0) m_pend = 0;
      for (int n = 0; n < N; n++) begin
        seed = nxt(seed);
        m_prio[n] = (t == 1) ? 2'd2 : seed[9:8];
      end
      load_model();
      chk("R7 resolve", 32'(pend_num), 32'(exp_num()));
      chk("R6 any", 32'(pend_any), 32'((m_en & m_pend) != 0));
    end

    // R4 input edge sets pending, held level does not re-set
    wr(12'h280, '1); wr(12'h100, '1);
    @(negedge clk); irq[5] = 1;
    @(negedge clk);
    rd(12'h200, d); chk("R4 edge sets", d, 32'h20);
    wr(12'h280, 32'h20); @(negedge clk);
    rd(12'h200, d); chk("R4 level held", d, 0);
    irq = 0;

    // R9 edge and clear-pending in the same cycle
    @(negedge clk); irq[7] = 1; we = 1; addr = 12'h280; wdata = 32'h80;
    @(negedge clk); we = 0;
    rd(12'h200, d); chk("R9 clear wins", d, 0);
    irq = 0;

    // R8 acknowledge handshake
    foreach (m_prio[i]) m_prio[i] = 3;
    m_prio[3] = 1; m_prio[9] = 0;
    m_en = '1; m_pend = 32'h208;
    load_model();
    chk("R8 before ack", 32'(pend_num), 25);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    chk("R8 active num", 32'(active_num), 25);
    chk("R8 active vld", 32'(active_vld), 1);
    chk("R8 next pending", 32'(pend_num), 19);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    chk("R8 ack ignored", 32'(active_num), 25);
    chk("R8 pend kept", 32'(pend_num), 19);
    @(negedge clk); eoi = 1;
    @(negedge clk); eoi = 0;
    chk("R8 eoi", 32'(active_vld), 0);
    chk("R8 eoi num", 32'(active_num), 0);
    // R9 ack clear against a same-cycle edge on the acked line
    @(negedge clk); ack = 1; irq[3] = 1;
    @(negedge clk); ack = 0;
    chk("R8 second ack", 32'(active_num), 19);
    rd(12'h200, d); chk("R9 ack beats edge", d, 0);
    chk("R6 none left", 32'(pend_any), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule